// File: doc/BRIEF.md
# Audio Codec Register Initialization Sequencer

This block brings a serial audio codec out of reset by issuing a fixed series of eleven control-register writes over an I2C write-only master. Each write is sent to that master as a device address byte and two payload bytes. The first payload byte holds the 7-bit register index and bit 8 of the 9-bit register value. The second payload byte holds value bits 7..0. The block starts one write with a single-cycle request. It then waits for the master's completion pulse, which carries an acknowledge status, before it prepares the next write.

The codec is set up as a bus slave: its bit clock and frame clock come from outside. Its data format is left-justified with 16-bit words. The headphone level is not a constant. It is taken from the `vol_level` input, so a key-control block can change it. Once the sequence has finished, any difference between `vol_level` and the level last written causes the headphone register to be written again, and no other register. The block signals the end of the sequence with a level output, and keeps a sticky flag when any write is not acknowledged.

Top module: `codec_init_seq`

## Requirements
- R1: The first write after reset goes to register index 0x0F with value 0x000 (payload bytes 0x1E, 0x00). `init_done` and `nack_error` are 0 after reset.
- R2: The writes come in this order, as (index, value) pairs: (0x0F,0x000), (0x00,0x097), (0x01,0x097), (0x02,vol), (0x03,vol), (0x04,0x012), (0x05,0x000), (0x06,0x000), (0x07,0x001), (0x08,0x000), (0x09,0x001). The first payload byte is {index[6:0], value[8]} and the second is value[7:0].
- R3: The value 0x001 written to index 0x07 encodes left-justified format (bits 1:0 = 01), 16-bit words (bits 3:2 = 00) and slave operation (bit 6 = 0).
- R4: The value written to indices 0x02 and 0x03 is {1'b1, 1'b0, L}. L is the `vol_level` sampled when the index 0x02 write is prepared, and the index 0x03 write reuses that same L.
- R5: `wr_req` is high for exactly one cycle per write. No new request is issued until `wr_done` returns, and a `wr_done` pulse with no write outstanding has no effect.
- R6: `init_done` rises in the cycle after the eleventh `wr_done` and stays high until reset.
- R7: The write to index 0x09 (activation) is the last write of the sequence, after all other registers.
- R8: `nack_error` is set by a `wr_done` that comes with `wr_nack` high while a write is outstanding, and stays set until reset. The sequence still runs to its end.
- R9: After `init_done`, if `vol_level` differs from the level last written, exactly one write to index 0x02 with value {1'b1, 1'b0, vol_level} is issued. If the level is unchanged, no write is issued.
- R10: `wr_dev_byte` is always 0x34, which is the 7-bit device address 0x1A followed by a write bit of 0.
- R11: If `vol_level` changes during the sequence after index 0x02 has been written, the new level is written to index 0x02 once the sequence has finished.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vol_level | input | 7 | Headphone output level |
| wr_req | output | 1 | One-cycle request to start a write |
| wr_dev_byte | output | 8 | Device address byte with the write bit |
| wr_hi_byte | output | 8 | First payload byte: register index and value bit 8 |
| wr_lo_byte | output | 8 | Second payload byte: value bits 7..0 |
| wr_done | input | 1 | Write-complete pulse from the I2C master |
| wr_nack | input | 1 | No-acknowledge status, valid together with wr_done |
| init_done | output | 1 | The full sequence has completed |
| nack_error | output | 1 | Sticky flag: a write was not acknowledged |

## Verification
The bench serves each write with a delayed done pulse. It compares every payload byte against the ordered list, so a design that swaps registers, puts the activation write early or drops value bit 8 into the wrong byte shows up as a byte miscompare. It changes the level in the middle of the sequence, just after the left headphone write. A design that takes a fresh snapshot for the right channel would then write mismatched levels, and one that compares against the live input would never rewrite. A done pulse with nack is sent while nothing is outstanding, which catches designs that set the error flag or advance without a request. A held level must produce no rewrite, so a design that rewrites on every cycle would stream requests.

// File: rtl/codec_init_pkg.sv
package codec_init_pkg;
  localparam int NUM_WRITES = 11;
  localparam int STEP_W     = $clog2(NUM_WRITES);
  localparam int VOL_W      = 7;
  localparam int IDX_W      = 7;
  localparam int VAL_W      = 9;

  // step positions with behaviour attached to them
  localparam int STEP_VOL_L = 3;
  localparam int STEP_VOL_R = 4;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic [VAL_W-1:0] val;
  } reg_wr_t;

  typedef enum logic [1:0] {
    SQ_LOAD = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2,
    SQ_RUN  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/codec_rst_sync.sv
module codec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/codec_init_rom.sv
module codec_init_rom
  import codec_init_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  input  logic [VOL_W-1:0]  vol,
  output reg_wr_t           word
);
  always_comb begin
    word = '{idx: 7'h0F, val: 9'h000};
    unique case (step)
      STEP_W'(0):  word = '{idx: 7'h0F, val: 9'h000}; // codec reset
      STEP_W'(1):  word = '{idx: 7'h00, val: 9'h097}; // left line input muted
      STEP_W'(2):  word = '{idx: 7'h01, val: 9'h097}; // right line input muted
      STEP_W'(3):  word = '{idx: 7'h02, val: {2'b10, vol}}; // left headphone, both channels
      STEP_W'(4):  word = '{idx: 7'h03, val: {2'b10, vol}}; // right headphone
      STEP_W'(5):  word = '{idx: 7'h04, val: 9'h012}; // analog routing: DAC selected
      STEP_W'(6):  word = '{idx: 7'h05, val: 9'h000}; // digital path, DAC unmuted
      STEP_W'(7):  word = '{idx: 7'h06, val: 9'h000}; // all blocks powered
      STEP_W'(8):  word = '{idx: 7'h07, val: 9'h001}; // left-justified, 16 bit, slave
      STEP_W'(9):  word = '{idx: 7'h08, val: 9'h000}; // sampling control
      STEP_W'(10): word = '{idx: 7'h09, val: 9'h001}; // activate interface
      default:     word = '{idx: 7'h0F, val: 9'h000};
    endcase
  end
endmodule

// File: rtl/codec_init_ctrl.sv
module codec_init_ctrl
  import codec_init_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VOL_W-1:0]  vol_level,
  input  logic              wr_done,
  input  logic              wr_nack,
  output logic [STEP_W-1:0] rom_step,
  output logic [VOL_W-1:0]  rom_vol,
  input  reg_wr_t           rom_word,
  output logic              wr_req,
  output reg_wr_t           word_q,
  output logic              init_done,
  output logic              nack_error
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_WRITES - 1);
  localparam logic [STEP_W-1:0] VOL_L     = STEP_W'(STEP_VOL_L);
  localparam logic [STEP_W-1:0] VOL_R     = STEP_W'(STEP_VOL_R);

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [VOL_W-1:0]  vol_sent_q;
  logic              retrig_q, retrig_d;
  logic              init_d, nack_d;
  logic              load_en, vol_cap_en;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    retrig_d = retrig_q;
    init_d   = init_done;
    nack_d   = nack_error;
    unique case (state_q)
      SQ_LOAD: state_d = SQ_REQ;
      SQ_REQ:  state_d = SQ_WAIT;
      SQ_WAIT: begin
        if (wr_done) begin
          if (wr_nack) nack_d = 1'b1;
          if (retrig_q) begin
            retrig_d = 1'b0;
            state_d  = SQ_RUN;
          end else if (step_q == LAST_STEP) begin
            init_d  = 1'b1;
            state_d = SQ_RUN;
          end else begin
            step_d  = step_q + STEP_W'(1);
            state_d = SQ_LOAD;
          end
        end
      end
      SQ_RUN: begin
        if (vol_level != vol_sent_q) begin
          retrig_d = 1'b1;
          state_d  = SQ_LOAD;
        end
      end
      default: state_d = SQ_LOAD;
    endcase
  end

  // the retrigger reuses the left-headphone entry; the right entry reuses the snapshot
  assign rom_step   = retrig_q ? VOL_L : step_q;
  assign rom_vol    = (!retrig_q && step_q == VOL_R) ? vol_sent_q : vol_level;
  assign load_en    = (state_q == SQ_LOAD);
  assign vol_cap_en = load_en && (retrig_q || step_q == VOL_L);
  assign wr_req     = (state_q == SQ_REQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SQ_LOAD;
      step_q     <= '0;
      retrig_q   <= 1'b0;
      init_done  <= 1'b0;
      nack_error <= 1'b0;
    end else begin
      state_q    <= state_d;
      step_q     <= step_d;
      retrig_q   <= retrig_d;
      init_done  <= init_d;
      nack_error <= nack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (load_en) word_q <= rom_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          vol_sent_q <= '0;
    else if (vol_cap_en) vol_sent_q <= vol_level;
  end
endmodule

// File: rtl/codec_init_seq.sv
module codec_init_seq
  import codec_init_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h1A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VOL_W-1:0] vol_level,
  output logic             wr_req,
  output logic [7:0]       wr_dev_byte,
  output logic [7:0]       wr_hi_byte,
  output logic [7:0]       wr_lo_byte,
  input  logic             wr_done,
  input  logic             wr_nack,
  output logic             init_done,
  output logic             nack_error
);
  logic              rst_int_n;
  logic [STEP_W-1:0] rom_step;
  logic [VOL_W-1:0]  rom_vol;
  reg_wr_t           rom_word;
  reg_wr_t           word_q;

  codec_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  codec_init_rom u_rom (
    .step (rom_step),
    .vol  (rom_vol),
    .word (rom_word)
  );

  codec_init_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .vol_level  (vol_level),
    .wr_done    (wr_done),
    .wr_nack    (wr_nack),
    .rom_step   (rom_step),
    .rom_vol    (rom_vol),
    .rom_word   (rom_word),
    .wr_req     (wr_req),
    .word_q     (word_q),
    .init_done  (init_done),
    .nack_error (nack_error)
  );

  assign wr_dev_byte = {DEV_ADDR, 1'b0};
  assign wr_hi_byte  = {word_q.idx, word_q.val[8]};
  assign wr_lo_byte  = word_q.val[7:0];
endmodule

// File: rtl/codec_init_checker.sv
module codec_init_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_req,
  input logic [7:0] wr_dev_byte,
  input logic [7:0] wr_hi_byte,
  input logic [7:0] wr_lo_byte,
  input logic       wr_done,
  input logic       wr_nack,
  input logic       init_done,
  input logic       nack_error
);
  logic       pend_q;
  logic [4:0] done_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      done_cnt_q <= '0;
    end else begin
      if (wr_req) pend_q <= 1'b1;
      else if (wr_done) pend_q <= 1'b0;
      if (pend_q && wr_done && !init_done && done_cnt_q != 5'd31)
        done_cnt_q <= done_cnt_q + 5'd1;
    end
  end

  p_dev_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dev_byte == 8'h34);
  p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !wr_req);
  p_no_req_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !wr_req);
  p_word_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !wr_done) |=> ($stable(wr_hi_byte) && $stable(wr_lo_byte)));
  p_init_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  p_init_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> (done_cnt_q == 5'd11));
  p_nack_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nack_error |=> nack_error);
  p_nack_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && wr_done && wr_nack) |=> nack_error);
endmodule

bind codec_init_seq codec_init_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_req      (wr_req),
  .wr_dev_byte (wr_dev_byte),
  .wr_hi_byte  (wr_hi_byte),
  .wr_lo_byte  (wr_lo_byte),
  .wr_done     (wr_done),
  .wr_nack     (wr_nack),
  .init_done   (init_done),
  .nack_error  (nack_error)
);

// File: tb/codec_init_seq_bench.sv
`timescale 1ns/1ps
module codec_init_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] vol_level;
  logic       wr_req;
  logic [7:0] wr_dev_byte, wr_hi_byte, wr_lo_byte;
  logic       wr_done, wr_nack;
  logic       init_done, nack_error;

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;

  codec_init_seq u_codec_init_seq (
    .clk(clk), .rst_n(rst_n), .vol_level(vol_level),
    .wr_req(wr_req), .wr_dev_byte(wr_dev_byte),
    .wr_hi_byte(wr_hi_byte), .wr_lo_byte(wr_lo_byte),
    .wr_done(wr_done), .wr_nack(wr_nack),
    .init_done(init_done), .nack_error(nack_error)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  // expected (index, value) for each step, from the requirement list
  function automatic logic [15:0] exp_word(input int s, input logic [6:0] v);
    logic [6:0] ix;
    logic [8:0] vl;
    case (s)
      0: begin ix = 7'h0F; vl = 9'h000; end
      1: begin ix = 7'h00; vl = 9'h097; end
      2: begin ix = 7'h01; vl = 9'h097; end
      3: begin ix = 7'h02; vl = {2'b10, v}; end
      4: begin ix = 7'h03; vl = {2'b10, v}; end
      5: begin ix = 7'h04; vl = 9'h012; end
      6: begin ix = 7'h05; vl = 9'h000; end
      7: begin ix = 7'h06; vl = 9'h000; end
      8: begin ix = 7'h07; vl = 9'h001; end
      9: begin ix = 7'h08; vl = 9'h000; end
      default: begin ix = 7'h09; vl = 9'h001; end
    endcase
    return {ix, vl[8], vl[7:0]};
  endfunction

  // waits for a request, checks it, answers after a delay
  task automatic serve_write(input logic [15:0] exp_b, input bit nack, input string rq);
    int w = 0;
    while (wr_req !== 1'b1 && w < 200) begin @(negedge clk); w++; end
    chk(wr_req === 1'b1, {rq, "/R5 request"}, int'(wr_req), 1);
    chk(wr_hi_byte === exp_b[15:8], {rq, " hi byte"}, int'(wr_hi_byte), int'(exp_b[15:8]));
    chk(wr_lo_byte === exp_b[7:0], {rq, " lo byte"}, int'(wr_lo_byte), int'(exp_b[7:0]));
    @(negedge clk);
    chk(wr_req === 1'b0, "R5 single-cycle request", int'(wr_req), 0);
    repeat (3) @(negedge clk);
    chk(wr_req === 1'b0, "R5 no request while pending", int'(wr_req), 0);
    wr_done = 1'b1; wr_nack = nack;
    @(negedge clk);
    wr_done = 1'b0; wr_nack = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_done = 1'b0; wr_nack = 1'b0;
    repeat (3) @(negedge clk);
    chk(init_done === 1'b0, "R1 init_done after reset", int'(init_done), 0);
    chk(nack_error === 1'b0, "R1 nack_error after reset", int'(nack_error), 0);
    chk(wr_dev_byte === 8'h34, "R10 device byte", int'(wr_dev_byte), 8'h34);
    rst_n = 1'b1;
  endtask

  // full sequence; nack_step < 0 means all writes acknowledged
  task automatic t_full_init(input logic [6:0] v, input int nack_step, input logic [6:0] v_after4);
    for (int s = 0; s < 11; s++) begin
      string tag;
      tag = (s == 0) ? "R1" : (s == 8) ? "R3" : (s == 10) ? "R7" : (s == 3 || s == 4) ? "R4" : "R2";
      if (s == 10) chk(init_done === 1'b0, "R6 low before last write", int'(init_done), 0);
      serve_write(exp_word(s, v), (s == nack_step), tag);
      if (s == 3) vol_level = v_after4;
    end
    chk(init_done === 1'b1, "R6 high after eleventh write", int'(init_done), 1);
    chk(nack_error === (nack_step >= 0), "R8 nack flag", int'(nack_error), int'(nack_step >= 0));
  endtask

  task automatic t_quiet(input int n, input string rq);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wr_req === 1'b1) seen = 1'b1;
    end
    chk(seen == 1'b0, rq, int'(seen), 0);
  endtask

  task automatic t_stray_done();
    logic prev;
    prev = nack_error;
    wr_done = 1'b1; wr_nack = 1'b1;
    @(negedge clk);
    wr_done = 1'b0; wr_nack = 1'b0;
    t_quiet(10, "R5 stray done starts nothing");
    chk(nack_error === prev, "R8 stray nack ignored", int'(nack_error), int'(prev));
    chk(init_done === 1'b1, "R6 stays high", int'(init_done), 1);
  endtask

  task automatic t_vol_change(input logic [6:0] v);
    vol_level = v;
    serve_write(exp_word(3, v), 1'b0, "R9 volume rewrite");
    t_quiet(30, "R9 only one rewrite");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !ended) begin
      ended = 1'b1;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    vol_level = 7'h79;
    do_reset();
    t_full_init(7'h79, -1, 7'h79);
    t_quiet(40, "R9 no rewrite when level unchanged");
    t_stray_done();
    t_vol_change(7'h30);
    t_vol_change(7'h7F);

    vol_level = 7'h40;
    do_reset();
    t_full_init(7'h40, 5, 7'h55);
    serve_write(exp_word(3, 7'h55), 1'b0, "R11 level changed mid-sequence");
    t_quiet(30, "R11 single catch-up write");
    chk(nack_error === 1'b1, "R8 flag remains set", int'(nack_error), 1);

    ended = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule